// File: doc/BRIEF.md
# Task-Event Serial Port Register Front End

This block is the software-facing register front end of a simple serial port. It uses a task/event model. Single-cycle 32-bit word-addressed writes trigger tasks (start/stop transmit, start/stop receive, suspend). They also update sticky event flags, an interrupt mask with direct, set and clear addresses, a write-one-to-clear error-source register, pin-select and baud configuration words, and the transmit data register. Reads are combinational from the current state and have no side effects.

The bit-level engine is outside the block and talks to it through strobes. `txStrobe` presents an accepted byte on `txByte`, and the engine answers with `txDone` when the byte is gone. `rxGotByte` reports a received byte, and `rxBreak` reports a line break. A single level interrupt is formed combinationally from the registered event flags and the mask. The whole peripheral is gated by a global enable that only one key value opens.

Top module: `sertask_top`

Register word addresses (on `busAddr`): start-receive 0x00, stop-receive 0x01, start-transmit 0x02, stop-transmit 0x03, suspend 0x04, receive-ready event 0x10, transmit-ready event 0x11, error event 0x12, receive-timeout event 0x13, mask direct 0x20, mask set 0x21, mask clear 0x22, error source 0x30, enable 0x31, transmit data 0x32, baud 0x33, pin-select 0..3 at 0x34..0x37.

## Requirements
- R1: After reset every register reads zero, with two exceptions: the four pin-select words read 0xFFFFFFFF and the baud word reads 0x04000000. The enable, running and pending flags are clear. Pin-select and baud words hold the value last written.
- R2: `irq` is high exactly when some event flag is set and its mask bit is set. The mask bits are bit 0 receive-ready, bit 1 transmit-ready, bit 2 error and bit 3 receive-timeout. With a zero mask `irq` is low.
- R3: Writing 4 to the enable address enables the block, and reading that address then returns 4. Any other nonzero value leaves the enable state unchanged. Writing 0 disables the block, stops transmit and receive, and sets the receive-timeout event.
- R4: While disabled, every read returns 0, and every write other than to the enable address has no effect.
- R5: A write to the direct mask address loads bits [3:0]. A write to the set address ORs the value in, and a write to the clear address removes the bits written as 1. All three addresses read back the mask, zero-extended.
- R6: Writing exactly 1 to start-transmit lets transmit run. Writing exactly 1 to stop-transmit or to suspend stops it. Other values have no effect.
- R7: Writing exactly 1 to stop-receive or to suspend stops receive and sets the receive-timeout event. Writing 1 to start-receive lets receive run.
- R8: A `rxBreak` pulse sets error-source bits [1:0] and the error event. Writing the error-source register clears the bits written as 1.
- R9: An event reads as 1 in bit 0 when set. `rxGotByte` sets receive-ready only while receive runs. Receive-ready is cleared only by writing 0 to it, and a nonzero write has no effect. Each of the other three events takes 1 on a nonzero write and 0 on a zero write.
- R10: A transmit-data write is accepted only while transmit runs and no byte is pending. On the next cycle `txStrobe` pulses for one cycle with the low byte on `txByte`, and the byte is readable at the transmit-data address. `txDone` while a byte is pending sets transmit-ready and clears pending.
- R11: A hardware set (`rxGotByte`, `txDone`, `rxBreak`) in the same cycle as a software write that would clear the same event or error-source bits wins: the bits end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for one cycle |
| busAddr | input | 8 | Word address for writes and reads |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| rxGotByte | input | 1 | Receiver got a byte |
| rxBreak | input | 1 | Receiver saw a line break |
| txByte | output | 8 | Byte handed to the transmitter |
| txStrobe | output | 1 | One-cycle pulse: `txByte` is valid |
| txDone | input | 1 | Transmitter finished the pending byte |
| irq | output | 1 | Level interrupt |

## Verification
The hazardous overlap is a hardware event set and a software write to the same flag landing on one clock edge. The cases are `txDone` with a zero write to transmit-ready, `rxGotByte` with a zero write to receive-ready, and `rxBreak` with a write-one-to-clear of the error source. The bench drives each pair in a single cycle and reads the flag back, expecting it set. A behavioural model is compared against `irq`, `txStrobe` and `txByte` on every clock, so a mis-ordered priority also shows up as a wrong interrupt level.

// File: rtl/sertask_pkg.sv
package sertask_pkg;
  parameter int ADDR_W  = 8;
  parameter int DATA_W  = 32;
  parameter int BYTE_W  = 8;
  parameter int NUM_PIN = 4;
  parameter int ERR_W   = 4;
  parameter int NUM_EV  = 4;

  parameter int ENABLE_KEY = 4;
  parameter logic [DATA_W-1:0] PIN_RESET  = 32'hFFFF_FFFF;
  parameter logic [DATA_W-1:0] BAUD_RESET = 32'h0400_0000;
  parameter logic [ERR_W-1:0]  BREAK_BITS = ERR_W'(3);

  // event positions, shared by the flag vector and the mask
  parameter int EV_RXRDY = 0;
  parameter int EV_TXRDY = 1;
  parameter int EV_ERROR = 2;
  parameter int EV_RXTO  = 3;

  parameter logic [ADDR_W-1:0] A_START_RX = 8'h00;
  parameter logic [ADDR_W-1:0] A_STOP_RX  = 8'h01;
  parameter logic [ADDR_W-1:0] A_START_TX = 8'h02;
  parameter logic [ADDR_W-1:0] A_STOP_TX  = 8'h03;
  parameter logic [ADDR_W-1:0] A_SUSPEND  = 8'h04;
  parameter logic [ADDR_W-1:0] A_EV_RXRDY = 8'h10;
  parameter logic [ADDR_W-1:0] A_EV_TXRDY = 8'h11;
  parameter logic [ADDR_W-1:0] A_EV_ERROR = 8'h12;
  parameter logic [ADDR_W-1:0] A_EV_RXTO  = 8'h13;
  parameter logic [ADDR_W-1:0] A_INT_MASK = 8'h20;
  parameter logic [ADDR_W-1:0] A_INT_SET  = 8'h21;
  parameter logic [ADDR_W-1:0] A_INT_CLR  = 8'h22;
  parameter logic [ADDR_W-1:0] A_ERR_SRC  = 8'h30;
  parameter logic [ADDR_W-1:0] A_ENABLE   = 8'h31;
  parameter logic [ADDR_W-1:0] A_TX_DATA  = 8'h32;
  parameter logic [ADDR_W-1:0] A_BAUD     = 8'h33;
  parameter logic [ADDR_W-1:0] A_PIN_BASE = 8'h34;

  typedef struct packed {
    logic               clrRxRdy;
    logic               wrTxRdy;
    logic               wrErr;
    logic               wrTo;
    logic               wrMask;
    logic               setMask;
    logic               clrMask;
    logic               clrErr;
    logic               raiseTo;
    logic               acceptTx;
    logic               txFinish;
    logic               rxSet;
    logic               wrBaud;
    logic [NUM_PIN-1:0] wrPin;
  } strobe_t;
endpackage

// File: rtl/sertask_ctrl.sv
module sertask_ctrl
  import sertask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxGotByte,
  input  logic              txDone,
  output strobe_t           st,
  output logic              enabled,
  output logic              txStrobe
);
  logic txRun, rxRun, txPending;
  logic hit, isOne, isZero;
  logic startTx, stopTx, startRx, stopRx, enSet, enClr;

  always_comb begin
    st      = '0;
    startTx = 1'b0;
    stopTx  = 1'b0;
    startRx = 1'b0;
    stopRx  = 1'b0;
    enSet   = 1'b0;
    enClr   = 1'b0;
    hit     = busWrite && (enabled || busAddr == A_ENABLE);
    isOne   = busWdata == DATA_W'(1);
    isZero  = busWdata == '0;
    if (hit) begin
      case (busAddr)
        A_START_RX: startRx = isOne;
        A_STOP_RX:  stopRx  = isOne;
        A_START_TX: startTx = isOne;
        A_STOP_TX:  stopTx  = isOne;
        A_SUSPEND: begin
          stopTx = isOne;
          stopRx = isOne;
        end
        A_EV_RXRDY: st.clrRxRdy = isZero;
        A_EV_TXRDY: st.wrTxRdy  = 1'b1;
        A_EV_ERROR: st.wrErr    = 1'b1;
        A_EV_RXTO:  st.wrTo     = 1'b1;
        A_INT_MASK: st.wrMask   = 1'b1;
        A_INT_SET:  st.setMask  = 1'b1;
        A_INT_CLR:  st.clrMask  = 1'b1;
        A_ERR_SRC:  st.clrErr   = 1'b1;
        A_ENABLE: begin
          enSet  = busWdata == DATA_W'(ENABLE_KEY);
          enClr  = isZero;
          stopTx = isZero;
          stopRx = isZero;
        end
        A_TX_DATA:  st.acceptTx = txRun && !txPending;
        A_BAUD:     st.wrBaud   = 1'b1;
        default: ;
      endcase
      for (int i = 0; i < NUM_PIN; i++) begin
        if (busAddr == A_PIN_BASE + ADDR_W'(i)) st.wrPin[i] = 1'b1;
      end
    end
    st.raiseTo  = stopRx;
    st.txFinish = txDone && txPending;
    st.rxSet    = rxGotByte && rxRun;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled   <= 1'b0;
      txRun     <= 1'b0;
      rxRun     <= 1'b0;
      txPending <= 1'b0;
      txStrobe  <= 1'b0;
    end else begin
      if (enSet)      enabled <= 1'b1;
      else if (enClr) enabled <= 1'b0;
      if (startTx)     txRun <= 1'b1;
      else if (stopTx) txRun <= 1'b0;
      if (startRx)     rxRun <= 1'b1;
      else if (stopRx) rxRun <= 1'b0;
      if (st.acceptTx)      txPending <= 1'b1;
      else if (st.txFinish) txPending <= 1'b0;
      txStrobe <= st.acceptTx;
    end
  end

  // R10: a pending byte stays pending until the transmitter answers
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    txPending && !txDone |=> txPending);
  // R10: the strobe only accompanies a byte that is now pending
  p_strobe_pend_r10: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> txPending);
  // R3: a zero written to the enable address shuts everything down
  p_disable_r3: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && busAddr == A_ENABLE && busWdata == '0 |=> !enabled && !txRun && !rxRun);
  // R4: while disabled, other writes leave the run flags alone
  p_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !enabled && busWrite && busAddr != A_ENABLE |=> $stable(txRun) && $stable(rxRun));
endmodule

// File: rtl/sertask_regs.sv
module sertask_regs
  import sertask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              enabled,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxBreak,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] txByte,
  output logic              irq
);
  logic [NUM_EV-1:0] evFlag;
  logic [NUM_EV-1:0] intMask;
  logic [ERR_W-1:0]  errSrc;
  logic [DATA_W-1:0] baudWord;
  logic [DATA_W-1:0] pinSel [NUM_PIN];
  logic [DATA_W-1:0] rdMux;
  logic              wrVal;

  assign wrVal = |busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evFlag   <= '0;
      intMask  <= '0;
      errSrc   <= '0;
      baudWord <= BAUD_RESET;
      txByte   <= '0;
    end else begin
      if (st.rxSet)         evFlag[EV_RXRDY] <= 1'b1;
      else if (st.clrRxRdy) evFlag[EV_RXRDY] <= 1'b0;
      if (st.txFinish)      evFlag[EV_TXRDY] <= 1'b1;
      else if (st.wrTxRdy)  evFlag[EV_TXRDY] <= wrVal;
      if (rxBreak)          evFlag[EV_ERROR] <= 1'b1;
      else if (st.wrErr)    evFlag[EV_ERROR] <= wrVal;
      if (st.raiseTo)       evFlag[EV_RXTO]  <= 1'b1;
      else if (st.wrTo)     evFlag[EV_RXTO]  <= wrVal;

      if (st.wrMask)       intMask <= busWdata[NUM_EV-1:0];
      else if (st.setMask) intMask <= intMask | busWdata[NUM_EV-1:0];
      else if (st.clrMask) intMask <= intMask & ~busWdata[NUM_EV-1:0];

      errSrc <= (errSrc & ~(st.clrErr ? busWdata[ERR_W-1:0] : '0))
              | (rxBreak ? BREAK_BITS : '0);

      if (st.wrBaud)   baudWord <= busWdata;
      if (st.acceptTx) txByte   <= busWdata[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            pinSel[g] <= PIN_RESET;
      else if (st.wrPin[g]) pinSel[g] <= busWdata;
    end
  end

  assign irq = |(evFlag & intMask);

  always_comb begin
    rdMux = '0;
    case (busAddr)
      A_EV_RXRDY: rdMux = DATA_W'(evFlag[EV_RXRDY]);
      A_EV_TXRDY: rdMux = DATA_W'(evFlag[EV_TXRDY]);
      A_EV_ERROR: rdMux = DATA_W'(evFlag[EV_ERROR]);
      A_EV_RXTO:  rdMux = DATA_W'(evFlag[EV_RXTO]);
      A_INT_MASK, A_INT_SET, A_INT_CLR: rdMux = DATA_W'(intMask);
      A_ERR_SRC:  rdMux = DATA_W'(errSrc);
      A_ENABLE:   rdMux = DATA_W'(ENABLE_KEY);
      A_TX_DATA:  rdMux = DATA_W'(txByte);
      A_BAUD:     rdMux = baudWord;
      default: ;
    endcase
    for (int i = 0; i < NUM_PIN; i++) begin
      if (busAddr == A_PIN_BASE + ADDR_W'(i)) rdMux = pinSel[i];
    end
    busRdata = enabled ? rdMux : '0;
  end

  // R2: nothing unmasked, no interrupt
  p_mask_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    intMask == '0 |-> !irq);
  // R9: receive-ready survives anything but a zero write
  p_rxrdy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    evFlag[EV_RXRDY] && !st.clrRxRdy |=> evFlag[EV_RXRDY]);
  // R8: a break always lands in both the event and the source bits
  p_break_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxBreak |=> evFlag[EV_ERROR] && errSrc[1:0] == 2'b11);
  // R11: completion beats a same-cycle software clear
  p_txdone_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    st.txFinish |=> evFlag[EV_TXRDY]);
endmodule

// File: rtl/sertask_top.sv
module sertask_top
  import sertask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxGotByte,
  input  logic              rxBreak,
  output logic [BYTE_W-1:0] txByte,
  output logic              txStrobe,
  input  logic              txDone,
  output logic              irq
);
  strobe_t st;
  logic    enabled;

  sertask_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .rxGotByte(rxGotByte), .txDone(txDone),
    .st(st), .enabled(enabled), .txStrobe(txStrobe)
  );

  sertask_regs u_regs (
    .clk(clk), .rstN(rstN), .st(st), .enabled(enabled), .busAddr(busAddr),
    .busWdata(busWdata), .rxBreak(rxBreak), .busRdata(busRdata),
    .txByte(txByte), .irq(irq)
  );
endmodule

// File: tb/sertask_top_bench.sv
`timescale 1ns/1ps
module sertask_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxGotByte = 1'b0, rxBreak = 1'b0, txDone = 1'b0;
  logic [7:0]  txByte;
  logic        txStrobe, irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sertask_top u_sertask_top (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxGotByte(rxGotByte),
    .rxBreak(rxBreak), .txByte(txByte), .txStrobe(txStrobe),
    .txDone(txDone), .irq(irq)
  );

  // behavioural reference: flags as plain bits
  bit mEn, mTxRun, mRxRun, mPend, mStrobe;
  bit mRxRdy, mTxRdy, mErr, mTo;
  bit [3:0] mMask, mErrSrc;
  bit [7:0] mByte;
  bit hit, acc, fin, rxs;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {mEn, mTxRun, mRxRun, mPend, mStrobe} = '0;
      {mRxRdy, mTxRdy, mErr, mTo} = '0;
      mMask = 0; mErrSrc = 0; mByte = 0;
    end else begin
      hit = busWrite && (mEn || busAddr == 8'h31);
      acc = hit && busAddr == 8'h32 && mTxRun && !mPend;
      fin = txDone && mPend;
      rxs = rxGotByte && mRxRun;
      mStrobe = acc;
      if (acc) mByte = busWdata[7:0];
      if (acc) mPend = 1; else if (fin) mPend = 0;
      if (hit) begin
        case (busAddr)
          8'h00: if (busWdata == 1) mRxRun = 1;
          8'h01: if (busWdata == 1) begin mRxRun = 0; mTo = 1; end
          8'h02: if (busWdata == 1) mTxRun = 1;
          8'h03: if (busWdata == 1) mTxRun = 0;
          8'h04: if (busWdata == 1) begin mTxRun = 0; mRxRun = 0; mTo = 1; end
          8'h10: if (busWdata == 0) mRxRdy = 0;
          8'h11: mTxRdy = busWdata != 0;
          8'h12: mErr = busWdata != 0;
          8'h13: mTo = busWdata != 0;
          8'h20: mMask = busWdata[3:0];
          8'h21: mMask = mMask | busWdata[3:0];
          8'h22: mMask = mMask & ~busWdata[3:0];
          8'h30: mErrSrc = mErrSrc & ~busWdata[3:0];
          8'h31: if (busWdata == 4) mEn = 1;
                 else if (busWdata == 0) begin mEn = 0; mTxRun = 0; mRxRun = 0; mTo = 1; end
          default: ;
        endcase
      end
      if (rxs) mRxRdy = 1;
      if (fin) mTxRdy = 1;
      if (rxBreak) begin mErr = 1; mErrSrc = mErrSrc | 4'd3; end
    end
  end

  // every-clock comparison of the outputs
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (irq !== ((mRxRdy & mMask[0]) | (mTxRdy & mMask[1]) | (mErr & mMask[2]) | (mTo & mMask[3]))) begin
        errors++;
        $display("FAIL R2 irq actual=%0b expected=%0b at %0t", irq,
          (mRxRdy & mMask[0]) | (mTxRdy & mMask[1]) | (mErr & mMask[2]) | (mTo & mMask[3]), $time);
      end
      checks++;
      if (txStrobe !== mStrobe) begin
        errors++;
        $display("FAIL R10 txStrobe actual=%0b expected=%0b at %0t", txStrobe, mStrobe, $time);
      end
      if (mStrobe) begin
        checks++;
        if (txByte !== mByte) begin
          errors++;
          $display("FAIL R10 txByte actual=%h expected=%h", txByte, mByte);
        end
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic drive(input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit got, input bit done, input bit brk);
    busWrite = w; busAddr = a; busWdata = d;
    rxGotByte = got; txDone = done; rxBreak = brk;
    @(negedge clk);
    busWrite = 0; rxGotByte = 0; txDone = 0; rxBreak = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rdE(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    checks++;
    if (busRdata !== exp) begin
      errors++;
      $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, busRdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic chkIrq(input bit exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkIrq(0, "R1");
    // disabled: reads zero, writes ignored
    rdE(8'h34, 0, "R4");
    rdE(8'h33, 0, "R4");
    wr(8'h20, 32'hF);
    wr(8'h02, 1);
    wr(8'h31, 5);
    rdE(8'h33, 0, "R3");
    wr(8'h31, 4);
    rdE(8'h31, 4, "R3");
    rdE(8'h33, 32'h0400_0000, "R1");
    for (int i = 0; i < 4; i++) rdE(8'h34 + 8'(i), 32'hFFFF_FFFF, "R1");
    rdE(8'h13, 0, "R1");
    rdE(8'h20, 0, "R4");
    wr(8'h32, 32'h11);
    rdE(8'h32, 0, "R4");
    // mask aliases
    wr(8'h20, 5);
    rdE(8'h20, 5, "R5");
    wr(8'h21, 2);
    rdE(8'h21, 7, "R5");
    wr(8'h22, 1);
    rdE(8'h22, 6, "R5");
    // transmit path
    wr(8'h02, 1);
    wr(8'h32, 32'hA5);
    wr(8'h32, 32'h3C);
    rdE(8'h32, 32'hA5, "R10");
    drive(0, 8'h00, 0, 0, 1, 0);
    rdE(8'h11, 1, "R10");
    chkIrq(1, "R2");
    wr(8'h32, 32'h5A);
    drive(1, 8'h11, 0, 0, 1, 0);
    rdE(8'h11, 1, "R11");
    wr(8'h11, 0);
    rdE(8'h11, 0, "R9");
    wr(8'h11, 9);
    rdE(8'h11, 1, "R9");
    wr(8'h11, 0);
    // receive path
    drive(0, 8'h00, 0, 1, 0, 0);
    rdE(8'h10, 0, "R9");
    wr(8'h00, 1);
    drive(0, 8'h00, 0, 1, 0, 0);
    rdE(8'h10, 1, "R9");
    wr(8'h10, 5);
    rdE(8'h10, 1, "R9");
    wr(8'h10, 0);
    rdE(8'h10, 0, "R9");
    drive(1, 8'h10, 0, 1, 0, 0);
    rdE(8'h10, 1, "R11");
    wr(8'h10, 0);
    wr(8'h01, 1);
    rdE(8'h13, 1, "R7");
    drive(0, 8'h00, 0, 1, 0, 0);
    rdE(8'h10, 0, "R7");
    wr(8'h13, 0);
    rdE(8'h13, 0, "R9");
    // stop with a non-one value, then suspend
    wr(8'h03, 2);
    wr(8'h32, 32'h77);
    rdE(8'h32, 32'h77, "R6");
    drive(0, 8'h00, 0, 0, 1, 0);
    wr(8'h04, 1);
    rdE(8'h13, 1, "R7");
    wr(8'h32, 32'h88);
    rdE(8'h32, 32'h77, "R6");
    // error source
    drive(0, 8'h00, 0, 0, 0, 1);
    rdE(8'h30, 3, "R8");
    rdE(8'h12, 1, "R8");
    wr(8'h30, 1);
    rdE(8'h30, 2, "R8");
    drive(1, 8'h30, 3, 0, 0, 1);
    rdE(8'h30, 3, "R11");
    wr(8'h12, 0);
    rdE(8'h12, 0, "R9");
    // interrupt combining: mask=6, txRdy=1, rxTo=1
    chkIrq(1, "R2");
    wr(8'h11, 0);
    chkIrq(0, "R2");
    wr(8'h21, 8);
    chkIrq(1, "R2");
    wr(8'h20, 0);
    chkIrq(0, "R2");
    // disable and re-enable
    wr(8'h13, 0);
    wr(8'h02, 1);
    wr(8'h00, 1);
    wr(8'h31, 0);
    rdE(8'h13, 0, "R4");
    wr(8'h31, 4);
    rdE(8'h13, 1, "R3");
    wr(8'h32, 32'h44);
    rdE(8'h32, 32'h77, "R3");
    wr(8'h36, 32'h12);
    rdE(8'h36, 32'h12, "R1");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule